// File: doc/BRIEF.md
# Reset and Wake-up Sequencer

This block decides which kind of reset or wake-up the chip is going through and drives the matching reset outputs. Its inputs are a power-on detect level, an active-low external reset pin, a watchdog time-out strobe, a halt strobe, a wake-up request and a watchdog-clear strobe. The halt strobe comes from the core when it executes its halt instruction. The watchdog-clear strobe comes from the core when it executes its watchdog-clear instruction.

The block keeps two status flags, time-out (TO) and power-down (PD), so firmware can tell the cause of a reset. A full (cold) reset returns the whole chip to its initial state. A light (warm) reset reloads only the program counter and the stack pointer. A start-up timer holds the core stalled for 1024 clock cycles after power-up and after every exit from halt, so the oscillator has time to settle.

Power-on detect is the synchronous active-high reset of the block. The external pin passes through a two-flop synchronizer before any logic uses it.

Top module: `wake_reset_ctrl`

## Requirements
- R1: While `por_i` is high, `to_flag_o`, `pd_flag_o`, `run_en_o` and `warm_rst_o` are 0. After `por_i` falls, `cold_rst_o` pulses on the 1024th clock edge. `run_en_o` rises on the next edge. `run_en_o` stays low for the whole start-up count.
- R2: In the running state, a falling level on `ext_rst_n_i` produces a one-cycle `cold_rst_o` pulse on the third clock edge after the pin goes low, because of the two synchronizer flops and the edge detector. `to_flag_o` and `pd_flag_o` keep their values.
- R3: In the running state, `wdt_tmo_i` sampled high gives a `cold_rst_o` pulse and `to_flag_o`=1 on that same edge. `pd_flag_o` is unchanged.
- R4: In the running state, `halt_i` sampled high sets `pd_flag_o`=1 on that edge and enters the halted state. `run_en_o` falls on the following edge.
- R5: In the running state, `wdt_clr_i` clears both `to_flag_o` and `pd_flag_o` on the edge that samples it.
- R6: In the halted state, a watchdog time-out gives `to_flag_o`=1 and `pd_flag_o`=1 at once. It then starts the start-up count. When the count expires, `warm_rst_o` pulses and `cold_rst_o` does not.
- R7: In the halted state, an external reset gives `to_flag_o`=0 and `pd_flag_o`=1 and starts the start-up count. When the count expires, `cold_rst_o` pulses.
- R8: In the halted state, `wake_req_i` starts the start-up count and leaves both flags unchanged. When the count expires, no reset pulse is issued, and `run_en_o` rises one edge later.
- R9: During the start-up count, `wdt_tmo_i`, `wdt_clr_i`, `halt_i` and `ext_rst_n_i` have no effect on the flags or on the outputs.
- R10: Event priority in the running state is: external reset, then watchdog time-out, then halt, then watchdog clear. In the halted state it is: external reset, then watchdog time-out, then wake request.
- R11: `cold_rst_o` and `warm_rst_o` are never high together. A `warm_rst_o` pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on detect, synchronous active-high reset |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_tmo_i | input | 1 | Watchdog time-out strobe |
| halt_i | input | 1 | Halt instruction executed strobe |
| wake_req_i | input | 1 | Wake-up request while halted |
| wdt_clr_i | input | 1 | Watchdog-clear instruction executed strobe |
| cold_rst_o | output | 1 | One-cycle full reset pulse |
| warm_rst_o | output | 1 | One-cycle PC/SP-only reset pulse |
| run_en_o | output | 1 | Core run enable |
| to_flag_o | output | 1 | Time-out status flag |
| pd_flag_o | output | 1 | Power-down status flag |

## Verification
A wrong sequencer state shows at the ports within one edge:
- A stray halted state drops `run_en_o` one edge after the bad transition.
- A wrong pending reset kind appears as the wrong pulse when the 1024-cycle count expires.

An off-by-one in the start-up counter moves the pulse and the `run_en_o` rise by a whole cycle, so the bench samples those outputs exactly at the 1023rd, 1024th and 1025th edges. Flag corruption is visible on the same edge as the event that caused it.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_RUN   = 2'd1,
        ST_HALT  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_COLD = 2'd1,
        RK_WARM = 2'd2
    } rst_kind_e;

    typedef struct packed {
        logic to;
        logic pd;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '{to: 1'b0, pd: 1'b0};

    function automatic logic kind_is(rst_kind_e k, rst_kind_e want);
        return k == want;
    endfunction

endpackage

// File: rtl/wrc_pin_sync.sv
module wrc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_i,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= pin_n_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], pin_n_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign fall_o = prev & ~chain[STAGES-1];
endmodule

// File: rtl/wrc_sst_timer.sv
module wrc_sst_timer #(
    parameter int CNT_W = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic done_o
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   sum;

    assign sum = {1'b0, cnt} + (CNT_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst || !run_i) cnt <= '0;
        else               cnt <= sum[CNT_W-1:0];
    end

    assign done_o = run_i & sum[CNT_W];
endmodule

// File: rtl/wrc_fsm.sv
module wrc_fsm
    import wrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_fall_i,
    input  logic       wdt_i,
    input  logic       halt_i,
    input  logic       wake_i,
    input  logic       clr_i,
    input  logic       sst_done_i,
    output seq_state_e st_o,
    output logic       cold_o,
    output logic       warm_o,
    output logic       run_en_o,
    output flags_t     flags_o
);
    seq_state_e st_q, st_n;
    rst_kind_e  kind_q, kind_n;
    flags_t     fl_q, fl_n;
    logic       cold_n, warm_n;

    always_comb begin
        st_n   = st_q;
        kind_n = kind_q;
        fl_n   = fl_q;
        cold_n = 1'b0;
        warm_n = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (ext_fall_i) begin
                    cold_n = 1'b1;
                end else if (wdt_i) begin
                    cold_n  = 1'b1;
                    fl_n.to = 1'b1;
                end else if (halt_i) begin
                    fl_n.pd = 1'b1;
                    st_n    = ST_HALT;
                end else if (clr_i) begin
                    fl_n = FLAGS_CLEAR;
                end
            end
            ST_HALT: begin
                if (ext_fall_i) begin
                    fl_n   = '{to: 1'b0, pd: 1'b1};
                    kind_n = RK_COLD;
                    st_n   = ST_START;
                end else if (wdt_i) begin
                    fl_n   = '{to: 1'b1, pd: 1'b1};
                    kind_n = RK_WARM;
                    st_n   = ST_START;
                end else if (wake_i) begin
                    kind_n = RK_NONE;
                    st_n   = ST_START;
                end
            end
            default: begin
                if (sst_done_i) begin
                    cold_n = kind_is(kind_q, RK_COLD);
                    warm_n = kind_is(kind_q, RK_WARM);
                    st_n   = ST_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_START;
            kind_q   <= RK_COLD;
            fl_q     <= FLAGS_CLEAR;
            cold_o   <= 1'b0;
            warm_o   <= 1'b0;
            run_en_o <= 1'b0;
        end else begin
            st_q     <= st_n;
            kind_q   <= kind_n;
            fl_q     <= fl_n;
            cold_o   <= cold_n;
            warm_o   <= warm_n;
            run_en_o <= (st_q == ST_RUN);
        end
    end

    assign st_o    = st_q;
    assign flags_o = fl_q;
endmodule

// File: rtl/wake_reset_ctrl.sv
module wake_reset_ctrl
    import wrc_pkg::*;
#(
    parameter int SST_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_i,
    input  logic ext_rst_n_i,
    input  logic wdt_tmo_i,
    input  logic halt_i,
    input  logic wake_req_i,
    input  logic wdt_clr_i,
    output logic cold_rst_o,
    output logic warm_rst_o,
    output logic run_en_o,
    output logic to_flag_o,
    output logic pd_flag_o
);
    seq_state_e st;
    flags_t     flags;
    logic       ext_fall;
    logic       sst_done;

    wrc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (por_i),
        .pin_n_i (ext_rst_n_i),
        .fall_o  (ext_fall)
    );

    wrc_sst_timer #(.CNT_W(SST_W)) u_sst (
        .clk    (clk),
        .rst    (por_i),
        .run_i  (st == ST_START),
        .done_o (sst_done)
    );

    wrc_fsm u_fsm (
        .clk        (clk),
        .rst        (por_i),
        .ext_fall_i (ext_fall),
        .wdt_i      (wdt_tmo_i),
        .halt_i     (halt_i),
        .wake_i     (wake_req_i),
        .clr_i      (wdt_clr_i),
        .sst_done_i (sst_done),
        .st_o       (st),
        .cold_o     (cold_rst_o),
        .warm_o     (warm_rst_o),
        .run_en_o   (run_en_o),
        .flags_o    (flags)
    );

    assign to_flag_o = flags.to;
    assign pd_flag_o = flags.pd;
endmodule

// File: rtl/wrc_checker.sv
module wrc_checker
    import wrc_pkg::*;
(
    input logic       clk,
    input logic       por_i,
    input seq_state_e st,
    input logic       ext_fall,
    input logic       sst_done,
    input logic       wdt_tmo_i,
    input logic       halt_i,
    input logic       wdt_clr_i,
    input logic       cold_rst_o,
    input logic       warm_rst_o,
    input logic       run_en_o,
    input logic       to_flag_o,
    input logic       pd_flag_o
);
    p_excl_r11: assert property (@(posedge clk) disable iff (por_i)
        !(cold_rst_o && warm_rst_o));

    p_warm_once_r11: assert property (@(posedge clk) disable iff (por_i)
        warm_rst_o |=> !warm_rst_o);

    p_stall_r1: assert property (@(posedge clk) disable iff (por_i)
        (st == ST_START) |-> !run_en_o);

    p_wdt_run_r3: assert property (@(posedge clk) disable iff (por_i)
        (st == ST_RUN && wdt_tmo_i && !ext_fall) |=> (to_flag_o && cold_rst_o));

    p_halt_pd_r4: assert property (@(posedge clk) disable iff (por_i)
        (st == ST_RUN && halt_i && !wdt_tmo_i && !ext_fall) |=> pd_flag_o);

    p_clr_r5: assert property (@(posedge clk) disable iff (por_i)
        (st == ST_RUN && wdt_clr_i && !halt_i && !wdt_tmo_i && !ext_fall)
        |=> (!to_flag_o && !pd_flag_o));

    p_warm_flags_r6: assert property (@(posedge clk) disable iff (por_i)
        warm_rst_o |-> (to_flag_o && pd_flag_o));

    p_ext_halt_r7: assert property (@(posedge clk) disable iff (por_i)
        (st == ST_HALT && ext_fall) |=> (!to_flag_o && pd_flag_o));

    p_ignore_r9: assert property (@(posedge clk) disable iff (por_i)
        (st == ST_START && !sst_done) |=> $stable({to_flag_o, pd_flag_o}));
endmodule

bind wake_reset_ctrl wrc_checker u_chk (
    .clk        (clk),
    .por_i      (por_i),
    .st         (st),
    .ext_fall   (ext_fall),
    .sst_done   (sst_done),
    .wdt_tmo_i  (wdt_tmo_i),
    .halt_i     (halt_i),
    .wdt_clr_i  (wdt_clr_i),
    .cold_rst_o (cold_rst_o),
    .warm_rst_o (warm_rst_o),
    .run_en_o   (run_en_o),
    .to_flag_o  (to_flag_o),
    .pd_flag_o  (pd_flag_o)
);

// File: tb/tb_wake_reset_ctrl.sv
module tb_wake_reset_ctrl;
    logic clk = 1'b0;
    logic por = 1'b1;
    logic pin_n = 1'b1;
    logic wdt = 1'b0;
    logic halt = 1'b0;
    logic wake = 1'b0;
    logic clr = 1'b0;
    logic cold, warm, run, to_f, pd_f;
    int   n_chk = 0;
    int   n_bad = 0;

    always #10 clk = ~clk;

    wake_reset_ctrl dut (
        .clk         (clk),
        .por_i       (por),
        .ext_rst_n_i (pin_n),
        .wdt_tmo_i   (wdt),
        .halt_i      (halt),
        .wake_req_i  (wake),
        .wdt_clr_i   (clr),
        .cold_rst_o  (cold),
        .warm_rst_o  (warm),
        .run_en_o    (run),
        .to_flag_o   (to_f),
        .pd_flag_o   (pd_f)
    );

    // {wdt, clr, expected cold, expected TO, expected PD}, applied in the running state
    localparam logic [4:0] VEC [0:6] = '{
        5'b01000, 5'b10110, 5'b00010, 5'b01000, 5'b11110, 5'b00010, 5'b01000
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {cold, warm, run, to_f, pd_f};
    endfunction

    // at the negedge after the edge that entered start-up
    task automatic finish_startup(input string req, input logic c, input logic w,
                                  input logic t, input logic p, input int used);
        repeat (1023 - used) tick();
        chk(req, outs(), {1'b0, 1'b0, 1'b0, t, p});
        tick();
        chk(req, outs(), {c, w, 1'b0, t, p});
        tick();
        chk(req, outs(), {1'b0, 1'b0, 1'b1, t, p});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (all requirements)");
        summary();
        $finish;
    end

    initial begin
        // R1: held in power-on
        repeat (3) tick();
        chk("R1 reset state", outs(), 5'b00000);
        por = 1'b0;
        finish_startup("R1 power-up", 1'b1, 1'b0, 1'b0, 1'b0, 0);

        // R3, R5, R10: vector table in the running state
        for (int i = 0; i < 7; i++) begin
            wdt = VEC[i][4];
            clr = VEC[i][3];
            tick();
            wdt = 1'b0;
            clr = 1'b0;
            chk(i == 4 ? "R10 wdt over clear" : (VEC[i][4] ? "R3 wdt run" : "R5 clear"),
                {cold, warm, run, to_f, pd_f}, {VEC[i][2], 1'b0, 1'b1, VEC[i][1], VEC[i][0]});
        end

        // R2: external reset while running, TO=1 kept
        wdt = 1'b1; tick(); wdt = 1'b0;
        pin_n = 1'b0;
        tick(); chk("R2 sync edge1", outs(), 5'b00110);
        tick(); chk("R2 sync edge2", outs(), 5'b00110);
        tick(); chk("R2 pulse", outs(), 5'b10110);
        tick(); chk("R2 one cycle", outs(), 5'b00110);
        pin_n = 1'b1;
        repeat (3) tick();

        // R4: halt
        clr = 1'b1; tick(); clr = 1'b0;
        halt = 1'b1; tick(); halt = 1'b0;
        chk("R4 pd set", outs(), 5'b00101);
        tick();
        chk("R4 run drop", outs(), 5'b00001);

        // R6 + R9: watchdog wakes from halt, events during start-up ignored
        wdt = 1'b1; tick(); wdt = 1'b0;
        chk("R6 flags", outs(), 5'b00011);
        clr = 1'b1; wdt = 1'b1; halt = 1'b1; pin_n = 1'b0;
        tick();
        clr = 1'b0; wdt = 1'b0; halt = 1'b0;
        chk("R9 ignored in start-up", outs(), 5'b00011);
        repeat (3) tick();
        pin_n = 1'b1;
        chk("R9 pin ignored", outs(), 5'b00011);
        finish_startup("R6 warm", 1'b0, 1'b1, 1'b1, 1'b1, 4);
        repeat (3) tick();

        // R7: external reset wakes from halt
        halt = 1'b1; tick(); halt = 1'b0;
        tick();
        pin_n = 1'b0;
        repeat (3) tick();
        chk("R7 flags", outs(), 5'b00001);
        pin_n = 1'b1;
        finish_startup("R7 cold", 1'b1, 1'b0, 1'b0, 1'b1, 0);
        repeat (3) tick();

        // R8: plain wake request
        wdt = 1'b1; tick(); wdt = 1'b0;
        halt = 1'b1; tick(); halt = 1'b0;
        tick();
        wake = 1'b1; tick(); wake = 1'b0;
        chk("R8 flags kept", outs(), 5'b00011);
        finish_startup("R8 no pulse", 1'b0, 1'b0, 1'b1, 1'b1, 0);

        // R10: external reset beats simultaneous watchdog while running
        clr = 1'b1; tick(); clr = 1'b0;
        pin_n = 1'b0;
        tick(); tick();
        wdt = 1'b1; tick(); wdt = 1'b0;
        chk("R10 ext over wdt", outs(), 5'b10100);
        pin_n = 1'b1;
        repeat (3) tick();

        // R1: power-on in mid-run clears everything
        wdt = 1'b1; tick(); wdt = 1'b0;
        por = 1'b1; tick();
        chk("R1 re-power", outs(), 5'b00000);

        summary();
        $finish;
    end
endmodule